// File: doc/BRIEF.md
# Tone Reorder Buffer

This block sits behind a processing stage whose latency differs from tone to tone, so results for later tones can leave that stage before results for earlier ones. Every incoming result word is tagged with the index of the tone it belongs to. The block stores the word in a slot chosen by the low bits of that tag. It then hands the words on over a valid/ready interface strictly in ascending tone order, one tone at a time. A word is released only when the word for the next expected tone has arrived.

The payload is one packed word that holds a full small complex matrix. Its width follows from the matrix dimension and the element width. The slot count is a power of two. It must cover the largest distance by which one tone can overtake another, and that distance is set by the iteration cap of the upstream stage. A producer may run ahead of the oldest missing tone by at most that many tones. Beyond that window it is stalled, and a second word for a tone that is already held is refused and flagged as an error.

Top module: `tone_reorder_buf`

## Requirements
- R1: After synchronous reset, out_valid is 0, err is 0 and out_tag is 0. All slots are empty, so in_ready is 1 for any tag from 0 to DEPTH-1.
- R2: out_tag is the next expected tone. It rises by exactly 1, modulo 2^TAG_W, on each cycle with out_valid and out_ready both high, and holds in every other cycle.
- R3: out_valid is high only while the word tagged out_tag is held. When that word is accepted, out_valid rises in the next cycle. Words for later tones never make out_valid high while the expected tone is missing.
- R4: out_data equals the payload that was accepted with tag out_tag. This holds for any arrival order of the tones inside the window.
- R5: in_ready is 0 for any tag whose distance (in_tag - out_tag) mod 2^TAG_W is DEPTH or more. Such a word is not stored.
- R6: A tag inside the window whose slot is already held gives in_ready 0 and leaves the held payload unchanged. When in_valid is high in that case, err is set in the next cycle.
- R7: err stays at 1 until the next reset.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_tag and out_data stay unchanged.
- R9: The tag sequence wraps from 2^TAG_W-1 to 0, and order and payloads stay correct across the wrap.
- R10: In one cycle a word can be accepted and another released. With both sides active every cycle, the block passes one tone per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a tagged word |
| in_ready | output | 1 | Word is taken at this edge if in_valid |
| in_tag | input | TAG_W | Tone index of the offered word |
| in_data | input | DATA_W | Packed matrix payload |
| out_valid | output | 1 | Word for the expected tone is available |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_tag | output | TAG_W | Tone index being presented (next expected tone) |
| out_data | output | DATA_W | Payload of that tone |
| err | output | 1 | Sticky: a word hit a slot that was already held |

## Verification
The bench writes each group of four tones in every one of the 24 possible arrival orders. It checks that the tones always drain in ascending order with their own payloads, so a design that released in arrival order, or that read the wrong slot, shows mismatched tags or data. The group base moves forward through the tag space until it wraps, which catches pointer or window arithmetic that breaks at the wrap. Other tests present a tag one step beyond the window and a duplicate tag. A design without the window check would alias a future tone onto a pending slot, and one that let duplicates through would corrupt the held payload or leave err low. Tests with the consumer stalled and with producer and consumer both streaming check that held output stays stable and that throughput is one tone per cycle.

// File: rtl/tone_rob_pkg.sv
package tone_rob_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int unsigned mat_word_bits(input int unsigned dim,
                                                  input int unsigned elem_w);
        // real and imaginary part per element
        return dim * dim * 2 * elem_w;
    endfunction

endpackage

// File: rtl/tone_rob_store.sv
module tone_rob_store
    import tone_rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 256,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_held,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  hd_idx,
    output logic              hd_held,
    output logic [DATA_W-1:0] hd_data
);

    slot_state_e       state [DEPTH];
    logic [DATA_W-1:0] mem   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                state[g] <= SLOT_FREE;
            end else if (wr_en && wr_idx == MY_IDX) begin
                state[g] <= SLOT_HELD;
            end else if (clr_en && hd_idx == MY_IDX) begin
                state[g] <= SLOT_FREE;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == MY_IDX) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign wr_held = (state[wr_idx] == SLOT_HELD);
    assign hd_held = (state[hd_idx] == SLOT_HELD);
    assign hd_data = mem[hd_idx];

endmodule

// File: rtl/tone_rob_head.sv
module tone_rob_head #(
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [TAG_W-1:0] head_tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_tag <= '0;
        end else if (advance) begin
            head_tag <= head_tag + 1'b1;
        end
    end

endmodule

// File: rtl/tone_rob_admit.sv
module tone_rob_admit #(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [TAG_W-1:0] head_tag,
    input  logic             slot_held,
    output logic             in_ready,
    output logic             wr_en,
    output logic             collide
);

    localparam logic [TAG_W:0] WIN_LIMIT = (TAG_W + 1)'(DEPTH);

    logic [TAG_W-1:0] ahead;
    logic             in_win;

    assign ahead    = in_tag - head_tag;
    assign in_win   = ({1'b0, ahead} < WIN_LIMIT);
    assign in_ready = in_win && !slot_held;
    assign wr_en    = in_valid && in_ready;
    assign collide  = in_valid && in_win && slot_held;

endmodule

// File: rtl/tone_reorder_buf.sv
module tone_reorder_buf
    import tone_rob_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned MAT_DIM = 4,
    parameter int unsigned ELEM_W  = 8,
    parameter int unsigned DATA_W  = mat_word_bits(MAT_DIM, ELEM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              err
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    if (!is_pow2(DEPTH) || DEPTH < 2 || TAG_W <= IDX_W) begin : g_bad_cfg
        $error("tone_reorder_buf: DEPTH must be a power of two >= 2 and below 2**TAG_W");
    end

    logic [TAG_W-1:0] head_tag;
    logic             wr_en;
    logic             wr_held;
    logic             collide;
    logic             hd_held;
    logic             advance;

    tone_rob_head #(.TAG_W(TAG_W)) u_head (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .head_tag (head_tag)
    );

    tone_rob_admit #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_admit (
        .in_valid  (in_valid),
        .in_tag    (in_tag),
        .head_tag  (head_tag),
        .slot_held (wr_held),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .collide   (collide)
    );

    tone_rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (in_tag[IDX_W-1:0]),
        .wr_data (in_data),
        .wr_held (wr_held),
        .clr_en  (advance),
        .hd_idx  (head_tag[IDX_W-1:0]),
        .hd_held (hd_held),
        .hd_data (out_data)
    );

    assign out_valid = hd_held;
    assign out_tag   = head_tag;
    assign advance   = hd_held && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (collide) begin
            err <= 1'b1;
        end
    end

endmodule

// File: rtl/tone_reorder_buf_chk.sv
module tone_reorder_buf_chk #(
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned DATA_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [TAG_W-1:0]  in_tag,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TAG_W-1:0]  out_tag,
    input logic [DATA_W-1:0] out_data,
    input logic              err
);

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (out_tag == TAG_W'($past(out_tag) + 1'b1))); // R2

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(out_tag)); // R2

    AST_ARRIVE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_tag == out_tag) |=> out_valid); // R3

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(in_valid && !in_ready)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R7

endmodule

bind tone_reorder_buf tone_reorder_buf_chk #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .err       (err)
);

// File: tb/tone_reorder_buf_bench.sv
module tone_reorder_buf_bench;

    localparam int unsigned DEPTH  = 4;
    localparam int unsigned TAG_W  = 4;
    localparam int unsigned DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [TAG_W-1:0]  out_tag;
    logic [DATA_W-1:0] out_data;
    logic              err;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_rd = 0;
    int rnd    = 0;

    always #5 clk = ~clk;

    tone_reorder_buf #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .MAT_DIM(1), .ELEM_W(8)
    ) u_tone_reorder_buf (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_data(out_data), .err(err)
    );

    function automatic logic [DATA_W-1:0] pay(input int t, input int r);
        return DATA_W'((r % 256) * 256 + (t % 16) * 16 + 3);
    endfunction

    function automatic logic [TAG_W-1:0] tg(input int t);
        return TAG_W'(t);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic push(input int t, input logic [DATA_W-1:0] d, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_tag = tg(t); in_data = d;
        #1 chk(in_ready == 1'b1, req, "in_ready on accept", int'(in_ready), 1);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain(input logic [DATA_W-1:0] d, input string req);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
        chk(out_tag == tg(exp_rd), req, "out_tag", int'(out_tag), int'(tg(exp_rd)));
        chk(out_data == d, req, "out_data", int'(out_data), int'(d));
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
        exp_rd = exp_rd + 1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        exp_rd = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        in_tag = tg(0);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(err == 1'b0, "R1", "err after reset", int'(err), 0);
        chk(out_tag == '0, "R1", "out_tag after reset", int'(out_tag), 0);
        for (int t = 0; t < 4; t++) begin
            in_tag = tg(t); #1;
            chk(in_ready == 1'b1, "R1", "in_ready for tag in window", int'(in_ready), 1);
        end

        // R5 window limits: tag 4 and tag 15 lie outside [0,3]
        @(negedge clk);
        in_valid = 1'b1; in_tag = tg(4); in_data = pay(4, 99);
        #1 chk(in_ready == 1'b0, "R5", "in_ready tag beyond window", int'(in_ready), 0);
        @(negedge clk);
        in_tag = tg(15);
        #1 chk(in_ready == 1'b0, "R5", "in_ready tag behind head", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk(out_valid == 1'b0 && err == 1'b0, "R5", "no store from refused word",
               int'({out_valid, err}), 0);
        push(0, pay(0, 1), "R5");
        chk(err == 1'b0, "R5", "slot 0 free for tag 0", int'(err), 0);
        drain(pay(0, 1), "R5");
        @(negedge clk);
        in_tag = tg(4); #1;
        chk(out_valid == 1'b0, "R5", "tag 4 not stored earlier", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R5", "tag 4 admitted once window moved", int'(in_ready), 1);

        // R3 later tones do not release while expected one missing
        push(exp_rd + 1, pay(exp_rd + 1, 2), "R3");
        push(exp_rd + 2, pay(exp_rd + 2, 2), "R3");
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R3", "no release without expected tone", int'(out_valid), 0);
        push(exp_rd, pay(exp_rd, 2), "R3");
        drain(pay(exp_rd, 2), "R3");
        drain(pay(exp_rd, 2), "R3");
        drain(pay(exp_rd, 2), "R3");

        // R8 held output under stall
        push(exp_rd, pay(exp_rd, 3), "R8");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(out_valid == 1'b1 && out_data == pay(exp_rd, 3), "R8", "stable under stall",
                int'(out_data), int'(pay(exp_rd, 3)));
            chk(out_tag == tg(exp_rd), "R8", "tag stable under stall", int'(out_tag),
                int'(tg(exp_rd)));
        end
        drain(pay(exp_rd, 3), "R8");

        // R10 simultaneous accept and release, full rate streaming
        push(exp_rd, pay(exp_rd, 4), "R10");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_tag = tg(exp_rd + 1); in_data = pay(exp_rd + 1, 4);
            out_ready = 1'b1;
            #1;
            chk(in_ready == 1'b1, "R10", "in_ready while streaming", int'(in_ready), 1);
            chk(out_valid == 1'b1 && out_tag == tg(exp_rd), "R10", "tone per cycle",
                int'(out_tag), int'(tg(exp_rd)));
            chk(out_data == pay(exp_rd, 4), "R10", "stream data", int'(out_data),
                int'(pay(exp_rd, 4)));
            @(posedge clk);
            exp_rd = exp_rd + 1;
        end
        #1 in_valid = 1'b0; out_ready = 1'b0;
        drain(pay(exp_rd, 4), "R10");

        // R2 R4 R9 every arrival order of four tones, base wraps the tag space
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                            int base;
                            base = exp_rd;
                            rnd  = rnd + 1;
                            push(base + a, pay(base + a, rnd), "R4");
                            push(base + b, pay(base + b, rnd), "R4");
                            push(base + c, pay(base + c, rnd), "R4");
                            push(base + d, pay(base + d, rnd), "R4");
                            for (int k = 0; k < 4; k++)
                                drain(pay(base + k, rnd), "R2 R9");
                        end
                    end

        // R6 R7 duplicate tag
        push(exp_rd + 1, pay(exp_rd + 1, 150), "R6");
        @(negedge clk);
        in_valid = 1'b1; in_tag = tg(exp_rd + 1); in_data = pay(exp_rd + 1, 200);
        #1 chk(in_ready == 1'b0, "R6", "in_ready on held slot", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk(err == 1'b1, "R6", "err after collision", int'(err), 1);
        push(exp_rd, pay(exp_rd, 150), "R6");
        drain(pay(exp_rd, 150), "R6");
        drain(pay(exp_rd, 150), "R6");
        repeat (5) @(negedge clk);
        #1 chk(err == 1'b1, "R7", "err sticky", int'(err), 1);
        do_reset();
        #1 chk(err == 1'b0, "R7", "err cleared by reset", int'(err), 0);
        chk(out_tag == '0 && out_valid == 1'b0, "R1", "second reset state",
            int'({out_valid, out_tag}), 0);

        report();
    end

endmodule